// File: doc/BRIEF.md
# Indexed Block Configuration Register Target (SMBus)

This block is a two-wire bus target that holds a small bank of 8-bit configuration bytes. A host changes them with an indexed block write. The host sends the target address, a starting index and a byte count, then the data bytes. It reads them back with an indexed block read: it sends the address and index, then a repeated start and the read address. The target answers with a count byte followed by data beginning at the index.

SCL and SDA are brought into the system clock domain through short synchronizers. Start, stop and SCL edges are detected in that domain. The target pulls SDA low through an output enable, as an open-drain driver would. The bank contents leave the block on a flat parallel bus, so downstream logic can use the settings directly.

Top module: `smb_cfg_target`

## Requirements
- R1: After a synchronous reset the five bytes read index 0 = 0xFF, 1 = 0x0F, 2 = 0xFF, 3 = 0x2F, 4 = 0x00, and SDA is released.
- R2: The target answers only to the 7-bit address 0x69 (address byte 0xD2 for write, 0xD3 for read, R/W in bit 0). Any other address gets no ACK, and the target leaves SDA released until the next start or stop.
- R3: In a write, the target ACKs the address, the index N, the count X and every data byte. Data bytes land in registers N, N+1, ... because the index advances after each byte.
- R4: A write to an index above 4 is still ACKed and changes nothing. Reading such an index returns 0x00.
- R5: Bit 5 of byte 4 always reads 0, and writes to it are dropped.
- R6: After a repeated start with the read address, the target first sends the count byte 5 and then the data from index N upward, advancing after each byte.
- R7: When the host NACKs a read byte, the target stops driving SDA and sends nothing more until the next start. A detected stop always releases SDA.
- R8: Bits move MSB first. SDA is sampled on the SCL rising edge, and the target changes its SDA drive only while SCL is low.
- R9: A start or stop that arrives inside a byte discards the partial byte and writes nothing.
- R10: `cfg_q` carries register i on bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_q | output | 40 | Register bank contents, byte i at [8i+7:8i] |

## Verification
The checker assumes the host keeps SCL low for several system clocks after each falling edge and changes SDA only in that low phase, except when it forms a start or stop. The assertions on when SDA drive and register writes may change are only valid under that assumption. The bench drives every bit in quarter-period steps of four system clocks, so the synchronizer delay always ends well inside the low phase. It forms starts and stops only while it holds SDA itself and the target has released the line.

// File: rtl/smb_cfg_pkg.sv
// Shared types and constants for the SMBus configuration target.
// Assumes byte-wide registers; defaults and write masks are computed per index.
package smb_cfg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } fsm_state_t;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_INDEX,
        BK_COUNT,
        BK_DATA
    } byte_kind_t;

    // Reset value of register idx.
    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'hFF;
            1:       return 8'h0F;
            2:       return 8'hFF;
            3:       return 8'h2F;
            default: return 8'h00;
        endcase
    endfunction

    // Writable bits of register idx; byte 4 bit 5 is held at zero.
    function automatic logic [BYTE_W-1:0] reg_wmask(input int idx);
        return (idx == 4) ? 8'hDF : 8'hFF;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
// Brings SCL and SDA into the clk domain and flags SCL edges, start and stop.
// Assumes clk runs well above the SCL rate; lines reset to the idle-high level.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int PIPE_W = STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;
    logic              scl_p;
    logic              sda_p;

    // Shift both lines through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];
    assign scl_p = scl_pipe[STAGES];
    assign sda_p = sda_pipe[STAGES];

    // Edge and bus-condition decode on the synchronized values.
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
// Holds NUM_REGS configuration bytes with per-index defaults and write masks.
// Assumes one write strobe per data byte; out-of-range addresses are ignored.
module smb_reg_bank
    import smb_cfg_pkg::*;
#(
    parameter int NUM_REGS = 5,
    parameter int AW       = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              waddr,
    input  logic [BYTE_W-1:0]          wdata,
    input  logic [AW-1:0]              raddr,
    output logic [BYTE_W-1:0]          rdata,
    output logic [NUM_REGS*BYTE_W-1:0] q_flat
);

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_reg
            logic [BYTE_W-1:0] r;
            // Load the default on reset, else take masked data when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    r <= reg_default(g);
                else if (we && (waddr == AW'(g)))
                    r <= wdata & reg_wmask(g);
            end
            assign q_flat[g*BYTE_W +: BYTE_W] = r;
        end
    endgenerate

    // Read mux; unimplemented indexes return zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (raddr == AW'(i))
                rdata = q_flat[i*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/smb_proto_fsm.sv
// Bit and byte engine for indexed block write and read transactions.
// Assumes synchronized inputs; updates drive only on detected SCL falling edges.
module smb_proto_fsm
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 5,
    parameter int         AW       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rdata,
    output logic [AW-1:0]     ptr,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output logic [BYTE_W-1:0] wdata,
    output logic              sda_oe
);

    localparam int               CNT_W     = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] BYTE_DONE = CNT_W'(BYTE_W);
    localparam logic [BYTE_W-1:0] REG_COUNT = BYTE_W'(NUM_REGS);

    fsm_state_t        state;
    byte_kind_t        kind;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic              rw_bit;
    logic              host_ack;

    // Main transaction sequencer: bus conditions first, then SCL edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            kind     <= BK_ADDR;
            bitcnt   <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            rw_bit   <= 1'b0;
            host_ack <= 1'b0;
            ptr      <= '0;
            we       <= 1'b0;
            waddr    <= '0;
            wdata    <= '0;
            sda_oe   <= 1'b0;
        end else begin
            we <= 1'b0;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                state  <= ST_RX;
                kind   <= BK_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (scl_rise) begin
                case (state)
                    ST_RX: begin
                        rx_sr  <= {rx_sr[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    ST_TX:     bitcnt   <= bitcnt + 1'b1;
                    ST_TX_ACK: host_ack <= ~sda_s;
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (state)
                    ST_RX: begin
                        if (bitcnt == BYTE_DONE) begin
                            state  <= ST_RX_ACK;
                            sda_oe <= 1'b1;
                            case (kind)
                                BK_ADDR: begin
                                    rw_bit <= rx_sr[0];
                                    if (rx_sr[BYTE_W-1:1] != DEV_ADDR) begin
                                        state  <= ST_SKIP;
                                        sda_oe <= 1'b0;
                                    end
                                end
                                BK_INDEX: ptr <= AW'(rx_sr);
                                BK_COUNT: ;
                                BK_DATA: begin
                                    we    <= 1'b1;
                                    waddr <= ptr;
                                    wdata <= rx_sr;
                                    ptr   <= ptr + 1'b1;
                                end
                                default: ;
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        bitcnt <= '0;
                        if (kind == BK_ADDR && rw_bit) begin
                            state  <= ST_TX;
                            tx_sr  <= REG_COUNT;
                            sda_oe <= ~REG_COUNT[BYTE_W-1];
                        end else begin
                            state  <= ST_RX;
                            sda_oe <= 1'b0;
                            case (kind)
                                BK_ADDR:  kind <= BK_INDEX;
                                BK_INDEX: kind <= BK_COUNT;
                                default:  kind <= BK_DATA;
                            endcase
                        end
                    end
                    ST_TX: begin
                        if (bitcnt == BYTE_DONE) begin
                            state  <= ST_TX_ACK;
                            sda_oe <= 1'b0;
                        end else begin
                            tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~tx_sr[BYTE_W-2];
                        end
                    end
                    ST_TX_ACK: begin
                        bitcnt <= '0;
                        if (host_ack) begin
                            state  <= ST_TX;
                            tx_sr  <= rdata;
                            sda_oe <= ~rdata[BYTE_W-1];
                            ptr    <= ptr + 1'b1;
                        end else begin
                            state  <= ST_SKIP;
                            sda_oe <= 1'b0;
                        end
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/smb_cfg_target.sv
// Top level: line synchronizer, transaction engine and register bank.
// Assumes SDA is wired-AND externally; sda_oe = 1 pulls the line low.
module smb_cfg_target
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_q
);

    localparam int AW = 8;

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [AW-1:0]     ptr;
    logic              reg_we;
    logic [AW-1:0]     reg_waddr;
    logic [BYTE_W-1:0] reg_wdata;
    logic [BYTE_W-1:0] reg_rdata;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_proto_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rdata     (reg_rdata),
        .ptr       (ptr),
        .we        (reg_we),
        .waddr     (reg_waddr),
        .wdata     (reg_wdata),
        .sda_oe    (sda_oe)
    );

    smb_reg_bank #(.NUM_REGS(NUM_REGS), .AW(AW)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .waddr  (reg_waddr),
        .wdata  (reg_wdata),
        .raddr  (ptr),
        .rdata  (reg_rdata),
        .q_flat (cfg_q)
    );

endmodule

// File: rtl/smb_cfg_target_chk.sv
// Property checker for smb_cfg_target, bound to every instance of the top.
// Assumes the host changes SDA only while SCL is low, apart from start and stop.
module smb_cfg_target_chk
    import smb_cfg_pkg::*;
#(
    parameter int NUM_REGS = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       scl_i,
    input logic                       sda_oe,
    input logic [NUM_REGS*BYTE_W-1:0] cfg_q,
    input logic                       stop_det,
    input logic                       reg_we
);

    logic [NUM_REGS*BYTE_W-1:0] def_img;

    // Expected reset image built from the per-index defaults.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++)
            def_img[i*BYTE_W +: BYTE_W] = reg_default(i);
    end

    AST_RESET_DEFAULTS: assert property (@(posedge clk) !rst_n |=> (cfg_q == def_img) && !sda_oe); // R1

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_oe) |-> !scl_i); // R8

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> !sda_oe); // R7

    AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(cfg_q) |-> $past(reg_we)); // R3

    AST_WRITE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n) reg_we |-> !scl_i); // R9

    generate
        if (NUM_REGS > 4) begin : g_rsvd
            AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) cfg_q[4*BYTE_W+5] == 1'b0); // R5
        end
    endgenerate

endmodule

bind smb_cfg_target smb_cfg_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .cfg_q    (cfg_q),
    .stop_det (stop_det),
    .reg_we   (reg_we)
);

// File: tb/smb_cfg_target_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module smb_cfg_target_bench;

    localparam int Q = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        host_sda = 1'b1;
    logic        sda_oe;
    logic [39:0] cfg_q;
    logic        sda_bus;
    int          total = 0;
    int          bad = 0;
    int          drive_viol = 0;
    logic        oe_last = 1'b0;

    assign sda_bus = host_sda & ~sda_oe;

    always #10 clk = ~clk;

    smb_cfg_target u_smb_cfg_target (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe),
        .cfg_q  (cfg_q)
    );

    // R8 monitor: the drive may only change while SCL is low.
    always @(posedge clk) begin
        if (rst_n && (sda_oe !== oe_last) && scl) drive_viol++;
        oe_last <= sda_oe;
    end

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; half(); scl = 1'b1; half();
        host_sda = 1'b0; half(); scl = 1'b0; half();
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; half(); scl = 1'b1; half();
        host_sda = 1'b1; half(); half();
    endtask

    task automatic send_bit(input logic b);
        half(); host_sda = b; half(); scl = 1'b1; half(); half(); scl = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        half(); host_sda = 1'b1; half(); scl = 1'b1; half(); b = sda_bus; half(); scl = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~give_ack);
    endtask

    // Set the index with a write header, then read count and n bytes.
    task automatic read_from(input logic [7:0] idx, input int n, output logic [7:0] cnt,
                             output logic [7:0] d [4]);
        logic a;
        bus_start();
        wr_byte(8'hD2, a);
        wr_byte(idx, a);
        bus_start();
        wr_byte(8'hD3, a);
        chk("R6 read address ack", 40'(a), 40'd1);
        rd_byte(1'b1, cnt);
        for (int i = 0; i < n; i++) rd_byte(i != n - 1, d[i]);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R1 reset image", cfg_q, 40'h00_2F_FF_0F_FF);
        chk("R10 byte0 lane", 40'(cfg_q[7:0]), 40'hFF);
        chk("R10 byte3 lane", 40'(cfg_q[31:24]), 40'h2F);
        chk("R1 sda released", 40'(sda_oe), 40'd0);
    endtask

    task automatic t_write_basic();
        logic a0, a1, a2, a3, a4;
        bus_start();
        wr_byte(8'hD2, a0);
        wr_byte(8'h01, a1);
        wr_byte(8'h02, a2);
        wr_byte(8'hA5, a3);
        wr_byte(8'h3C, a4);
        bus_stop();
        chk("R2 write address ack", 40'(a0), 40'd1);
        chk("R3 index/count ack", 40'({a1, a2}), 40'b11);
        chk("R3 data ack", 40'({a3, a4}), 40'b11);
        chk("R3 auto-increment write", cfg_q, 40'h00_2F_3C_A5_FF);
        chk("R10 byte2 lane", 40'(cfg_q[23:16]), 40'h3C);
    endtask

    task automatic t_read_basic();
        logic [7:0] cnt;
        logic [7:0] d [4];
        read_from(8'h01, 3, cnt, d);
        chk("R6 count byte", 40'(cnt), 40'd5);
        chk("R6 data from index", 40'({d[0], d[1], d[2]}), 40'hA5_3C_2F);
        chk("R7 released after stop", 40'(sda_oe), 40'd0);
    endtask

    task automatic t_bad_addr();
        logic a0, a1;
        bus_start();
        wr_byte(8'hA0, a0);
        wr_byte(8'h00, a1);
        bus_stop();
        chk("R2 foreign address no ack", 40'(a0), 40'd0);
        chk("R2 later byte ignored", 40'(a1), 40'd0);
        chk("R2 no register change", cfg_q, 40'h00_2F_3C_A5_FF);
    endtask

    task automatic t_out_of_range();
        logic a0, a1, a2, a3;
        logic [7:0] cnt;
        logic [7:0] d [4];
        bus_start();
        wr_byte(8'hD2, a0);
        wr_byte(8'h07, a1);
        wr_byte(8'h01, a2);
        wr_byte(8'h55, a3);
        bus_stop();
        chk("R4 out-of-range data ack", 40'(a3), 40'd1);
        chk("R4 out-of-range no effect", cfg_q, 40'h00_2F_3C_A5_FF);
        read_from(8'h06, 1, cnt, d);
        chk("R4 out-of-range reads zero", 40'(d[0]), 40'h00);
    endtask

    task automatic t_reserved();
        logic a;
        logic [7:0] cnt;
        logic [7:0] d [4];
        bus_start();
        wr_byte(8'hD2, a);
        wr_byte(8'h04, a);
        wr_byte(8'h01, a);
        wr_byte(8'hFF, a);
        bus_stop();
        chk("R5 reserved bit dropped", 40'(cfg_q[39:32]), 40'hDF);
        read_from(8'h04, 1, cnt, d);
        chk("R5 reserved bit reads 0", 40'(d[0]), 40'hDF);
    endtask

    task automatic t_abort();
        logic a;
        logic [7:0] cnt;
        logic [7:0] d [4];
        bus_start();
        wr_byte(8'hD2, a);
        wr_byte(8'h00, a);
        wr_byte(8'h01, a);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        chk("R9 partial byte discarded", 40'(cfg_q[7:0]), 40'hFF);
        read_from(8'h00, 1, cnt, d);
        chk("R9 target usable after abort", 40'(d[0]), 40'hFF);
    endtask

    task automatic t_nack_end();
        logic a;
        logic [7:0] cnt;
        logic [7:0] d0;
        logic [7:0] extra;
        bus_start();
        wr_byte(8'hD2, a);
        wr_byte(8'h02, a);
        bus_start();
        wr_byte(8'hD3, a);
        rd_byte(1'b1, cnt);
        rd_byte(1'b0, d0);
        half();
        chk("R7 released after NACK", 40'(sda_oe), 40'd0);
        rd_byte(1'b0, extra);
        bus_stop();
        chk("R6 data at index 2", 40'(d0), 40'h3C);
        chk("R7 nothing sent after NACK", 40'(extra), 40'hFF);
        chk("R8 drive changes in SCL low", 40'(drive_viol), 40'd0);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_write_basic();
        t_read_basic();
        t_bad_addr();
        t_out_of_range();
        t_reserved();
        t_abort();
        t_nack_end();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule